// File: doc/BRIEF.md
# Flag-Based Magnitude Comparator

This block compares two N-bit operands, A and B, in a single purely combinational path. It forms the difference A minus B in one adder. The adder takes B inverted and its carry-in is held at one. From that difference it derives four condition flags: carry, zero, negative and overflow. Every ordering and equality result comes from those flags, with no separate compare trees.

A single mode bit selects how the operands are read: as unsigned or as two's-complement signed numbers. The block raises exactly one of the less-than, equal and greater-than outputs. It also reports whether operand A is all ones or all zeros, using wide AND and wide NOR detectors. An independent per-bit XNOR equality path feeds an all-ones detector, and this result is cross-checked against the zero flag.

Top module: `magcmp_flags`

## Requirements
- R1: The carry flag is the carry out of A + ~B + 1, so it equals 1 exactly when A >= B as unsigned numbers.
- R2: The zero flag is 1 exactly when every bit of the difference A - B (modulo 2^N) is 0.
- R3: The negative flag equals bit N-1 of the difference A - B.
- R4: The overflow flag is 1 exactly when A[N-1] differs from B[N-1] and bit N-1 of the difference differs from A[N-1].
- R5: With mode_signed_i = 0 (unsigned), lt_o equals the inverse of the carry flag, that is A < B unsigned.
- R6: With mode_signed_i = 1 (signed), lt_o equals the negative flag XOR the overflow flag, that is A < B as two's-complement values.
- R7: eq_o is 1 exactly when A equals B, in either mode.
- R8: gt_o is 1 exactly when both lt_o and eq_o are 0, so exactly one of lt_o, eq_o, gt_o is 1.
- R9: ones_a_o is 1 exactly when all N bits of A are 1.
- R10: zeros_a_o is 1 exactly when all N bits of A are 0.
- R11: The four flags, eq_o, ones_a_o and zeros_a_o do not depend on mode_signed_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A (minuend) |
| opb_i | input | WIDTH | Operand B (subtrahend) |
| mode_signed_i | input | 1 | 0 = unsigned compare, 1 = signed compare |
| flag_c_o | output | 1 | Carry out of A + ~B + 1 |
| flag_z_o | output | 1 | Difference is zero |
| flag_n_o | output | 1 | Sign bit of the difference |
| flag_v_o | output | 1 | Signed overflow of the subtraction |
| lt_o | output | 1 | A less than B under the selected mode |
| eq_o | output | 1 | A equals B |
| gt_o | output | 1 | A greater than B under the selected mode |
| ones_a_o | output | 1 | A is all ones |
| zeros_a_o | output | 1 | A is all zeros |

## Verification
Every result is combinational, so each flag and relation is due in the same cycle as the operands and mode that produce it. No register lies between input and output. The bench drives a new operand pair on the falling clock edge and samples all outputs one nanosecond later, well before the next rising edge. It computes the expected values with native unsigned and signed comparison and subtraction, never through the adder structure. The mode-independence check applies the same operands twice with only the mode flipped, and compares the mode-free outputs in each setting.

// File: rtl/magcmp_pkg.sv
// Package: shared types for the flag-based magnitude comparator.
// Assumes: nothing beyond two's-complement encoding of signed operands.
package magcmp_pkg;

    // Interpretation of the operands.
    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    // Condition flags of the subtraction A - B.
    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } cmp_flags_t;

endpackage

// File: rtl/magcmp_ones_detect.sv
// Module: wide all-ones detector built as a two-level AND tree.
// The vector is cut into groups of GROUP bits, and each group is ANDed.
// The group results are then ANDed together.
// Assumes: WIDTH >= 1; a final group may be shorter than GROUP.
module magcmp_ones_detect #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             all_ones_o
);
    localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

    logic [NGRP-1:0] grp_ones;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GROUP;
        localparam int HI = ((g + 1) * GROUP > WIDTH) ? WIDTH - 1 : (g + 1) * GROUP - 1;
        // Per-group AND of its slice.
        assign grp_ones[g] = &vec_i[HI:LO];
    end

    // Second level: all groups must be all ones.
    assign all_ones_o = &grp_ones;

    // R9: the tree result matches a direct reduction.
    always_comb begin
        a_r9_tree_matches : assert (all_ones_o == (vec_i == {WIDTH{1'b1}}))
            else $error("ones tree mismatch");
    end
endmodule

// File: rtl/magcmp_subtractor.sv
// Module: ripple subtractor that forms A + ~B + 1.
// It uses one full adder per bit, and the carry-in of bit 0 is tied high.
// Assumes: unsigned or two's-complement operands of equal width.
module magcmp_subtractor #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] diff_o,
    output logic             carry_o
);
    logic [WIDTH-1:0] opb_inv;
    logic [WIDTH:0]   cy;

    // Invert the subtrahend.
    assign opb_inv = ~opb_i;
    // The carry-in is held at one to complete the two's complement.
    assign cy[0]   = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic prop;
        // Full adder cell: propagate, sum and majority carry.
        assign prop      = opa_i[i] ^ opb_inv[i];
        assign diff_o[i] = prop ^ cy[i];
        assign cy[i+1]   = (opa_i[i] & opb_inv[i]) | (prop & cy[i]);
    end

    assign carry_o = cy[WIDTH];

    // R1: the ripple chain yields A - B and the unsigned no-borrow carry.
    always_comb begin
        a_r1_diff_value : assert (diff_o == WIDTH'(opa_i - opb_i))
            else $error("difference mismatch");
        a_r1_carry_no_borrow : assert (carry_o == (opa_i >= opb_i))
            else $error("carry mismatch");
    end
endmodule

// File: rtl/magcmp_flag_gen.sv
// Module: derives the C/Z/N/V flags from the difference and the operand signs.
// Assumes: diff_i is A - B and carry_i is the carry out of A + ~B + 1.
module magcmp_flag_gen
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] diff_i,
    input  logic             carry_i,
    input  logic             sign_a_i,
    input  logic             sign_b_i,
    output cmp_flags_t       flags_o
);
    localparam int MSB = WIDTH - 1;

    logic diff_zero;

    // The zero flag uses the shared detector on the inverted difference.
    magcmp_ones_detect #(.WIDTH(WIDTH), .GROUP(4)) u_zero_det (
        .vec_i      (~diff_i),
        .all_ones_o (diff_zero)
    );

    // Assemble the flags.
    always_comb begin
        flags_o.c = carry_i;
        flags_o.z = diff_zero;
        flags_o.n = diff_i[MSB];
        flags_o.v = (sign_a_i ^ sign_b_i) & (diff_i[MSB] ^ sign_a_i);
    end

    // R2, R3 and R4: the flags agree with the value of the difference.
    always_comb begin
        a_r2_zero_flag : assert (flags_o.z == (diff_i == '0))
            else $error("zero flag mismatch");
        a_r3_negative_flag : assert (flags_o.n == diff_i[MSB])
            else $error("negative flag mismatch");
        a_r4_no_overflow : assert (sign_a_i != sign_b_i || !flags_o.v)
            else $error("overflow with like signs");
    end
endmodule

// File: rtl/magcmp_flags.sv
// Module (top): flag-based magnitude comparator.
// One subtraction produces C/Z/N/V.
// The less-than, equal and greater-than outputs come from those flags.
// A mode bit selects unsigned or signed ordering.
// The block also has all-ones and all-zeros detectors on A.
// An XNOR equality path cross-checks the zero flag.
// Assumes: purely combinational use, so outputs are valid once the inputs settle.
module magcmp_flags
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             mode_signed_i,
    output logic             flag_c_o,
    output logic             flag_z_o,
    output logic             flag_n_o,
    output logic             flag_v_o,
    output logic             lt_o,
    output logic             eq_o,
    output logic             gt_o,
    output logic             ones_a_o,
    output logic             zeros_a_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] diff;
    logic             carry;
    cmp_flags_t       flags;
    cmp_mode_e        mode;
    logic             bits_equal;

    magcmp_subtractor #(.WIDTH(WIDTH)) u_sub (
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .diff_o  (diff),
        .carry_o (carry)
    );

    magcmp_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .diff_i   (diff),
        .carry_i  (carry),
        .sign_a_i (opa_i[MSB]),
        .sign_b_i (opb_i[MSB]),
        .flags_o  (flags)
    );

    // Per-bit XNOR followed by an all-ones detect: the cross-check equality path.
    magcmp_ones_detect #(.WIDTH(WIDTH), .GROUP(4)) u_eq_det (
        .vec_i      (~(opa_i ^ opb_i)),
        .all_ones_o (bits_equal)
    );

    // Wide AND on A.
    magcmp_ones_detect #(.WIDTH(WIDTH), .GROUP(4)) u_ones_det (
        .vec_i      (opa_i),
        .all_ones_o (ones_a_o)
    );

    // Wide NOR on A (an AND of the inverted bits).
    magcmp_ones_detect #(.WIDTH(WIDTH), .GROUP(4)) u_zeros_det (
        .vec_i      (~opa_i),
        .all_ones_o (zeros_a_o)
    );

    // Decode the mode bit.
    assign mode = cmp_mode_e'(mode_signed_i);

    // Drive the flag ports.
    always_comb begin
        flag_c_o = flags.c;
        flag_z_o = flags.z;
        flag_n_o = flags.n;
        flag_v_o = flags.v;
    end

    // Relations, all taken from the flags.
    always_comb begin
        lt_o = (mode == CMP_SIGNED) ? (flags.n ^ flags.v) : ~flags.c;
        eq_o = flags.z;
        gt_o = ~lt_o & ~flags.z;
    end

    // Checks on the relations against native comparisons and the XNOR path.
    always_comb begin
        a_r5_unsigned_lt : assert (mode_signed_i || (lt_o == (opa_i < opb_i)))
            else $error("unsigned lt mismatch");
        a_r6_signed_lt : assert (!mode_signed_i || (lt_o == ($signed(opa_i) < $signed(opb_i))))
            else $error("signed lt mismatch");
        a_r7_eq_paths_agree : assert (eq_o == bits_equal)
            else $error("zero flag and xnor equality disagree");
        a_r8_one_relation : assert ($onehot({lt_o, eq_o, gt_o}))
            else $error("relations not one-hot");
        a_r10_zeros_detect : assert (zeros_a_o == (opa_i == '0))
            else $error("zeros detect mismatch");
    end
endmodule

// File: tb/magcmp_flags_tb_top.sv
// Bench for magcmp_flags.
// It walks a vector table, then runs directed corner and mode tests.
module magcmp_flags_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b;
    logic         m;
    logic fc, fz, fn, fv, lt, eq, gt, ones, zeros;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    magcmp_flags #(.WIDTH(W)) dut_i (
        .opa_i(a), .opb_i(b), .mode_signed_i(m),
        .flag_c_o(fc), .flag_z_o(fz), .flag_n_o(fn), .flag_v_o(fv),
        .lt_o(lt), .eq_o(eq), .gt_o(gt), .ones_a_o(ones), .zeros_a_o(zeros)
    );

    // Vector table entries are {mode, A, B}.
    localparam int NV = 14;
    localparam logic [2*W:0] VEC [NV] = '{
        {1'b0, 16'h0005, 16'h0003},
        {1'b0, 16'h0003, 16'h0005},
        {1'b0, 16'h1234, 16'h1234},
        {1'b0, 16'hFFFF, 16'h0001},
        {1'b1, 16'hFFFF, 16'h0001},
        {1'b0, 16'h8000, 16'h7FFF},
        {1'b1, 16'h8000, 16'h7FFF},
        {1'b1, 16'h7FFF, 16'h8000},
        {1'b1, 16'h8000, 16'h0001},
        {1'b1, 16'h7FFF, 16'hFFFF},
        {1'b0, 16'h0000, 16'hFFFF},
        {1'b1, 16'hFFFE, 16'hFFFF},
        {1'b1, 16'hA5A5, 16'hA5A5},
        {1'b0, 16'hFFFF, 16'hFFFF}
    };

    task automatic cmp1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h mode=%0d actual=%0b expected=%0b", tag, a, b, m, act, exp);
        end
    endtask

    // Drive on the falling edge, then sample 1 ns later (the outputs are combinational).
    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tm);
        @(negedge clk);
        a = ta; b = tb; m = tm;
        #1;
    endtask

    // Expected values come from native arithmetic.
    task automatic check_all();
        logic [W-1:0] d;
        logic e_c, e_z, e_n, e_v, e_lt, e_eq, e_gt;
        d    = a - b;
        e_c  = (a >= b);
        e_z  = (d == '0);
        e_n  = d[W-1];
        e_v  = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]);
        e_lt = m ? ($signed(a) < $signed(b)) : (a < b);
        e_eq = (a == b);
        e_gt = !e_lt && !e_eq;
        cmp1("R1 carry", fc, e_c);
        cmp1("R2 zero", fz, e_z);
        cmp1("R3 negative", fn, e_n);
        cmp1("R4 overflow", fv, e_v);
        if (m) cmp1("R6 signed lt", lt, e_lt);
        else   cmp1("R5 unsigned lt", lt, e_lt);
        cmp1("R7 eq", eq, e_eq);
        cmp1("R8 gt", gt, e_gt);
        cmp1("R9 ones", ones, a == {W{1'b1}});
        cmp1("R10 zeros", zeros, a == '0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic s_c, s_z, s_n, s_v, s_eq, s_on, s_ze;
        a = '0; b = '0; m = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // State after reset with zero operands.
        #1;
        check_all();
        cmp1("R7 reset eq", eq, 1'b1);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][2*W-1:W], VEC[i][W-1:0], VEC[i][2*W]);
            check_all();
        end

        // Directed R4 cases: the overflow flag is set for the most negative value minus one.
        apply(16'h8000, 16'h0001, 1'b1);
        cmp1("R4 overflow set", fv, 1'b1);
        cmp1("R6 most-negative lt", lt, 1'b1);
        // The largest positive value minus -1 also overflows.
        apply(16'h7FFF, 16'hFFFF, 1'b1);
        cmp1("R4 overflow set pos", fv, 1'b1);
        cmp1("R6 gt after overflow", gt, 1'b1);

        // R11: the mode-free outputs do not change when only the mode changes.
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] xa, xb;
            xa = W'(16'h8000 + k * 16'h3001);
            xb = W'(16'h7FF0 - k * 16'h1F00);
            apply(xa, xb, 1'b0);
            s_c = fc; s_z = fz; s_n = fn; s_v = fv; s_eq = eq; s_on = ones; s_ze = zeros;
            apply(xa, xb, 1'b1);
            cmp1("R11 c stable", fc, s_c);
            cmp1("R11 z stable", fz, s_z);
            cmp1("R11 n stable", fn, s_n);
            cmp1("R11 v stable", fv, s_v);
            cmp1("R11 eq stable", eq, s_eq);
            cmp1("R11 ones stable", ones, s_on);
            cmp1("R11 zeros stable", zeros, s_ze);
            check_all();
        end

        // Walking single-bit B against A = 0, in both modes.
        for (int j = 0; j < W; j++) begin
            apply('0, W'(1) << j, 1'b0);
            check_all();
            apply('0, W'(1) << j, 1'b1);
            check_all();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule